// File: doc/BRIEF.md
# Power-Fail Protected Byte-Wide SRAM

This block wraps a 2K x 8 storage array with the control decode of a common byte-wide static RAM and adds protection against a failing supply. Three active-low controls, chip enable, output enable and write enable, select one of four modes: deselected, read, read with outputs held off, and write. The bidirectional data bus is split into an input byte, an output byte and a drive-enable bit, so a pad ring or an on-chip bus mux can rebuild the tri-state pin.

Two digital status inputs stand in for analog sensing. `supply_ok` is high while the supply sits above the deselect trip point. While it is low, every control input is ignored, the outputs stay off and no write lands. `batt_low` is sampled only in the cycle where `supply_ok` rises. If the battery was low, an internal lock flag is set. The next write attempt is then swallowed, and that attempt clears the flag. This lets software detect a low battery by writing a complement and reading it back. The array itself is never cleared, so its contents survive any supply-fail interval.

Top module: `pfsram_wrap`

## Requirements
- R1: With `ce_n` high, `dout_en` is 0 and a write strobe leaves the addressed byte unchanged.
- R2: With `ce_n` low and `we_n` low, `din` is stored at `addr` on the clock edge, whatever the level of `oe_n`.
- R3: With `ce_n` low, `we_n` high and `oe_n` low, `dout_en` is 1 and `dout` shows the byte at `addr` in the same cycle.
- R4: With `ce_n` low and both `oe_n` and `we_n` high, `dout_en` is 0.
- R5: While `supply_ok` is 0, `dout_en` is 0 and no write is performed.
- R6: When `supply_ok` rises while `batt_low` is 1, the next write attempt is blocked and the lock flag is cleared by that attempt. The write after it is stored.
- R7: `batt_low` is sampled only in the cycle where `supply_ok` rises. Changes at other times do not block writes.
- R8: The array contents are kept across an interval with `supply_ok` low.
- R9: A low `we_n` turns `dout_en` off in the same cycle, even with `ce_n` and `oe_n` low.
- R10: While the outputs are not driven, `dout` is all zeros. After reset the lock flag is clear, so with `batt_low` 0 at power-up the first write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus, zero when not driven |
| dout_en | output | 1 | Bus drive enable |
| supply_ok | input | 1 | Supply above the deselect trip point |
| batt_low | input | 1 | Battery found low, sampled as supply returns |

## Verification
The bench builds the block with `ADDR_W` = 4 and `DATA_W` = 8. The whole array is then only sixteen bytes, so the lowest and highest addresses are both exercised, and every byte read back has been written by the bench beforehand. The shallow array also lets supply-fail cycles, the lock flag, and its interaction with a write on the same or the next cycle be reached within a few dozen clocks.

// File: rtl/pfsram_wrap.sv
module pfsram_wrap #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic              supply_ok,
  input  logic              batt_low
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic sok_q, bnok;
  logic sok_rise, sel, wr_try, lock, wr_do;

  assign sok_rise = supply_ok & ~sok_q;
  assign sel      = supply_ok & ~ce_n;
  assign wr_try   = sel & ~we_n;
  assign lock     = sok_rise ? batt_low : bnok;
  assign wr_do    = wr_try & ~lock;

  assign dout_en  = sel & we_n & ~oe_n;
  assign dout     = dout_en ? mem[addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sok_q <= 1'b0;
      bnok  <= 1'b0;
    end else begin
      sok_q <= supply_ok;
      bnok  <= lock & ~wr_try;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_do) mem[addr] <= din;
  end
endmodule

// File: rtl/pfsram_wrap_chk.sv
module pfsram_wrap_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              supply_ok,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              sok_q,
  input logic              flag
);
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);                                           // R1
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !ce_n && !oe_n && we_n) |-> dout_en);           // R3
  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);                                           // R4
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !dout_en);                                     // R5
  AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && supply_ok && sok_q && !ce_n && !we_n) |=> !flag);    // R6
  AST_LOCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && sok_q && (ce_n || we_n)) |=> $stable(flag));    // R7
  AST_WE_KILLS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en);                                          // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));                                   // R10
endmodule

bind pfsram_wrap pfsram_wrap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .supply_ok(supply_ok), .dout(dout), .dout_en(dout_en),
  .sok_q(sok_q), .flag(bnok)
);

// File: tb/test_pfsram_wrap.sv
module test_pfsram_wrap;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;
  logic supply_ok = 1'b1, batt_low = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pfsram_wrap #(.ADDR_W(AW), .DATA_W(DW)) i_pfsram_wrap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .supply_ok(supply_ok), .batt_low(batt_low)
  );

  // {req[3:0], ce_n, oe_n, we_n, addr[3:0], din[7:0], exp_en, exp_dout[7:0]}
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {4'd2, 3'b010, 4'd1,  8'hA5, 1'b0, 8'h00},  // R2 write, oe high
    {4'd9, 3'b000, 4'd2,  8'h3C, 1'b0, 8'h00},  // R9 write with oe low, bus off
    {4'd3, 3'b001, 4'd1,  8'h00, 1'b1, 8'hA5},  // R3 read
    {4'd2, 3'b001, 4'd2,  8'h00, 1'b1, 8'h3C},  // R2 write stored despite oe low
    {4'd1, 3'b110, 4'd1,  8'hFF, 1'b0, 8'h00},  // R1 deselected write
    {4'd1, 3'b001, 4'd1,  8'h00, 1'b1, 8'hA5},  // R1 byte unchanged
    {4'd4, 3'b011, 4'd1,  8'h00, 1'b0, 8'h00},  // R4 outputs held off
    {4'd2, 3'b010, 4'd15, 8'h81, 1'b0, 8'h00},  // R2 top address
    {4'd3, 3'b001, 4'd15, 8'h00, 1'b1, 8'h81},  // R3 top address
    {4'd1, 3'b101, 4'd15, 8'h00, 1'b0, 8'h00}   // R1 read controls, chip off
  };

  task automatic drive(input logic c, input logic o, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
    #1;
  endtask

  task automatic check(input string req, input logic en_exp, input logic [DW-1:0] d_exp);
    checks++;
    if (dout_en !== en_exp || dout !== d_exp) begin
      errors++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
               req, dout_en, dout, en_exp, d_exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state, bus idle
    #2;
    check("R10", 1'b0, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R10: first write after power-up with battery good is stored
    drive(1'b0, 1'b1, 1'b0, 4'd0, 8'hC3);
    drive(1'b0, 1'b0, 1'b1, 4'd0, 8'h00);
    check("R10", 1'b1, 8'hC3);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:17], VEC[i][16:9]);
      check($sformatf("R%0d", VEC[i][27:24]), VEC[i][8], VEC[i][7:0]);
    end

    // R5 / R8: supply fail, read and write ignored
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    supply_ok = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 4'd1, 8'h00);
    check("R5", 1'b0, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 4'd1, 8'h00);
    check("R5", 1'b0, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    supply_ok = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 4'd1, 8'h00);
    check("R5", 1'b1, 8'hA5);
    drive(1'b0, 1'b0, 1'b1, 4'd15, 8'h00);
    check("R8", 1'b1, 8'h81);

    // R6: battery low at supply return blocks exactly one write
    drive(1'b0, 1'b1, 1'b0, 4'd3, 8'h77);
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    supply_ok = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    supply_ok = 1'b1; batt_low = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    batt_low = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 4'd3, 8'h00);
    check("R8", 1'b1, 8'h77);
    drive(1'b0, 1'b1, 1'b0, 4'd3, 8'h11);
    drive(1'b0, 1'b0, 1'b1, 4'd3, 8'h00);
    check("R6", 1'b1, 8'h77);
    drive(1'b0, 1'b1, 1'b0, 4'd3, 8'h22);
    drive(1'b0, 1'b0, 1'b1, 4'd3, 8'h00);
    check("R6", 1'b1, 8'h22);

    // R6: write in the very cycle of the rise with battery low is blocked
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    supply_ok = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 4'd3, 8'h99);
    supply_ok = 1'b1; batt_low = 1'b1;
    #0;
    drive(1'b0, 1'b0, 1'b1, 4'd3, 8'h00);
    batt_low = 1'b0;
    check("R6", 1'b1, 8'h22);
    drive(1'b0, 1'b1, 1'b0, 4'd3, 8'h44);
    drive(1'b0, 1'b0, 1'b1, 4'd3, 8'h00);
    check("R6", 1'b1, 8'h44);

    // R7: battery low with supply steady has no effect
    batt_low = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 4'd4, 8'h5A);
    drive(1'b0, 1'b0, 1'b1, 4'd4, 8'h00);
    check("R7", 1'b1, 8'h5A);
    batt_low = 1'b0;

    // R9: we low during an active read turns the bus off at once
    drive(1'b0, 1'b0, 1'b1, 4'd4, 8'h00);
    check("R9", 1'b1, 8'h5A);
    drive(1'b0, 1'b0, 1'b0, 4'd4, 8'h6B);
    check("R9", 1'b0, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 4'd4, 8'h00);
    check("R2", 1'b1, 8'h6B);

    drive(1'b1, 1'b1, 1'b1, 4'd0, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule